// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The block gathers level-sensitive interrupt lines into groups of eight and drives one output per group toward a parent interrupt controller. A group output is high while at least one of its eight lines is both high and enabled. Input number `g*8 + k` is line `k` of group `g`.

Four consecutive groups share a 32-bit register bank. Software turns individual lines on through a write-one-to-set register and off through a separate write-one-to-clear register, so no read-modify-write is needed. Software can read back the enable bits to save and later restore them. A masked status word lists, for every line of a bank, whether that line is pending and enabled. Access uses a simple synchronous port with word addresses and 32-bit data. Read data is registered.

Top module: `intc_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every `group_irq` bit is 0 and `rdata` is 0.
- R2: A write to word offset 0 of a bank (byte offset 0x0) sets each enable bit whose `wdata` bit is 1. Bits written 0 keep their value. The new enables take effect on the clock edge that accepts the write.
- R3: A write to word offset 1 of a bank (byte offset 0x4) clears each enable bit whose `wdata` bit is 1. Bits written 0 keep their value.
- R4: A read of word offset 0 or word offset 1 returns the bank's current enable bits. A read of word offset 2 returns 0. Bits of groups beyond `NUM_GROUPS` read 0 and cannot be set.
- R5: A read of word offset 3 (byte offset 0xC) returns input AND enable for all 32 lines of the bank. A write to word offsets 2 or 3 changes no enable bit.
- R6: `group_irq[g]` equals, one clock after the inputs and enables are sampled, the OR over the eight lines of group g of input AND enable. A group whose lines are all disabled stays low.
- R7: Group g lives in bank g/4 (the word address bits above bit 1 select the bank, a 0x10-byte stride) at bits [8*(g%4)+7 : 8*(g%4)]. It combines inputs `irq_in[8*g+7 : 8*g]`.
- R8: A write to a bank index at or above the number of banks changes no enable bit. A read of such a bank returns 0.
- R9: `rdata` updates on the clock edge that samples `rd_en` and holds while `rd_en` is low. A read and a write in the same cycle return the enable value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_GROUPS*8 | Level-sensitive interrupt lines |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address: bank in the upper bits, register in bits [1:0] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| group_irq | output | NUM_GROUPS | One combined interrupt per group |

## Verification
A corrupted enable bit appears at the ports in two ways. A readback of the enable offsets shows it in the cycle after the read. A wrong `group_irq` level shows it one clock after the affected input goes high. A wrong bank or byte position shows up when a single input is walked across every line: a different group output rises. Set or clear logic that touches bits written 0, or a write that leaks into other banks, changes the saved enable image. Status reads of every bank expose that change, and they also expose any unmasked pending line.

// File: rtl/combiner_pkg.sv
package combiner_pkg;
    localparam int LINES_PER_GROUP = 8;
    localparam int GROUPS_PER_BANK = 4;
    localparam int BANK_W          = LINES_PER_GROUP * GROUPS_PER_BANK;

    // word offset within a bank; the value is the decoded register
    typedef enum logic [1:0] {
        OFS_SET  = 2'd0,
        OFS_CLR  = 2'd1,
        OFS_PAD  = 2'd2,
        OFS_STAT = 2'd3
    } reg_ofs_e;
endpackage

// File: rtl/combiner_enable_bank.sv
module combiner_enable_bank
    import combiner_pkg::*;
#(
    parameter int VALID_BITS = BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] en
);
    localparam logic [BANK_W-1:0] KEEP_MASK =
        (VALID_BITS >= BANK_W) ? {BANK_W{1'b1}} : BANK_W'((64'd1 << VALID_BITS) - 64'd1);

    typedef struct packed {
        logic [BANK_W-1:0] en;
    } bank_st_t;

    bank_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set_we) begin
            s_d.en = s_q.en | (wdata & KEEP_MASK);
        end
        if (clr_we) begin
            s_d.en = s_d.en & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en = s_q.en;
endmodule

// File: rtl/combiner_group_or.sv
module combiner_group_or
    import combiner_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LINES_PER_GROUP-1:0] lines,
    input  logic [LINES_PER_GROUP-1:0] en,
    output logic                       irq
);
    typedef struct packed {
        logic irq;
    } grp_st_t;

    grp_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = |(lines & en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = s_q.irq;
endmodule

// File: rtl/combiner_read_port.sv
module combiner_read_port
    import combiner_pkg::*;
#(
    parameter int NUM_BANKS  = 5,
    parameter int BANK_SEL_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic                        bank_ok,
    input  logic [BANK_SEL_W-1:0]       bank,
    input  reg_ofs_e                    ofs,
    input  logic [NUM_BANKS*BANK_W-1:0] en_all,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_pad,
    output logic [BANK_W-1:0]           rdata
);
    typedef struct packed {
        logic [BANK_W-1:0] rdata;
    } rd_st_t;

    rd_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_en) begin
            s_d.rdata = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_ok && (bank == BANK_SEL_W'(b))) begin
                    unique case (ofs)
                        OFS_SET, OFS_CLR: s_d.rdata = en_all[b*BANK_W +: BANK_W];
                        OFS_STAT:         s_d.rdata = en_all[b*BANK_W +: BANK_W] & irq_pad[b*BANK_W +: BANK_W];
                        default:          s_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;
endmodule

// File: rtl/intc_group_combiner.sv
module intc_group_combiner
    import combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] irq_in,
    input  logic                                wr_en,
    input  logic                                rd_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [BANK_W-1:0]                   wdata,
    output logic [BANK_W-1:0]                   rdata,
    output logic [NUM_GROUPS-1:0]               group_irq
);
    localparam int NUM_INPUTS = NUM_GROUPS * LINES_PER_GROUP;
    localparam int NUM_BANKS  = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK;
    localparam int BANK_SEL_W = ADDR_W - 2;
    localparam int PAD_W      = NUM_BANKS * BANK_W;

    logic [BANK_SEL_W-1:0] bank;
    reg_ofs_e              ofs;
    logic                  bank_ok;
    logic [PAD_W-1:0]      en_all;
    logic [PAD_W-1:0]      irq_pad;

    assign bank    = addr[ADDR_W-1:2];
    assign ofs     = reg_ofs_e'(addr[1:0]);
    assign bank_ok = (32'(bank) < 32'(NUM_BANKS));

    always_comb begin
        irq_pad                 = '0;
        irq_pad[NUM_INPUTS-1:0] = irq_in;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int REM_GROUPS = NUM_GROUPS - b * GROUPS_PER_BANK;
        localparam int VALID      = (REM_GROUPS >= GROUPS_PER_BANK) ? BANK_W : REM_GROUPS * LINES_PER_GROUP;
        logic hit;
        assign hit = wr_en && bank_ok && (bank == BANK_SEL_W'(b));

        combiner_enable_bank #(.VALID_BITS(VALID)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (hit && (ofs == OFS_SET)),
            .clr_we (hit && (ofs == OFS_CLR)),
            .wdata  (wdata),
            .en     (en_all[b*BANK_W +: BANK_W])
        );
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        combiner_group_or u_or (
            .clk   (clk),
            .rst_n (rst_n),
            .lines (irq_in[g*LINES_PER_GROUP +: LINES_PER_GROUP]),
            .en    (en_all[g*LINES_PER_GROUP +: LINES_PER_GROUP]),
            .irq   (group_irq[g])
        );
    end

    combiner_read_port #(
        .NUM_BANKS  (NUM_BANKS),
        .BANK_SEL_W (BANK_SEL_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .bank_ok (bank_ok),
        .bank    (bank),
        .ofs     (ofs),
        .en_all  (en_all),
        .irq_pad (irq_pad),
        .rdata   (rdata)
    );
endmodule

// File: rtl/combiner_checker.sv
module combiner_checker #(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_GROUPS*8-1:0]    irq_in,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [31:0]                rdata,
    input logic [NUM_GROUPS-1:0]      group_irq,
    input logic [((NUM_GROUPS+3)/4)*32-1:0] en_all
);
    localparam int NB = (NUM_GROUPS + 3) / 4;

    logic bank_out;
    assign bank_out = (32'(addr[ADDR_W-1:2]) >= 32'(NB));

    AST_EN_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_all & ~$past(en_all)) != '0) |-> $past(wr_en && addr[1:0] == 2'd0)); // R2

    AST_EN_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ((~en_all & $past(en_all)) != '0) |-> $past(wr_en && addr[1:0] == 2'd1)); // R3

    AST_PAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr[1:0] == 2'd2) |-> (rdata == 32'd0)); // R4

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr[1:0] == 2'd3) |-> $stable(en_all)); // R5

    AST_OUT_OF_RANGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && bank_out) |-> $stable(en_all)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata)); // R9

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        AST_GROUP_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            group_irq[g] |-> $past(|irq_in[g*8 +: 8])); // R6
        AST_GROUP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            $past(en_all[g*8 +: 8] == 8'd0) |-> !group_irq[g]); // R6
    end
endmodule

bind intc_group_combiner combiner_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .group_irq (group_irq),
    .en_all    (en_all)
);

// File: tb/tb_intc_group_combiner.sv
`timescale 1ns/1ps
module tb_intc_group_combiner;
    localparam int NG = 20;
    localparam int NB = 5;
    localparam int NI = NG * 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] irq_in = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NG-1:0] group_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] m_en [NB];

    always #2.5 clk = ~clk;

    intc_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .group_irq(group_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int bank, input int ofs, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(bank * 4 + ofs); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int bank, input int ofs, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(bank * 4 + ofs);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic logic [NG-1:0] exp_groups(input logic [NI-1:0] in);
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++)
            r[g] = |(in[g*8 +: 8] & m_en[g/4][(g%4)*8 +: 8]);
        return r;
    endfunction

    task automatic check_all_enables(input string req);
        logic [31:0] v;
        for (int b = 0; b < NB; b++) begin
            rd(b, 0, v);
            chk(req, 64'(v), 64'(m_en[b]));
        end
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] p;
        logic [NI-1:0] pat;
        for (int b = 0; b < NB; b++) m_en[b] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", 64'(group_irq), 64'd0);
        chk("R1", 64'(rdata), 64'd0);
        rst_n = 1'b1;
        check_all_enables("R1");

        // R6: all inputs high but nothing enabled
        irq_in = '1;
        repeat (2) @(negedge clk);
        chk("R6", 64'(group_irq), 64'd0);
        rd(2, 3, v);
        chk("R5", 64'(v), 64'd0);
        irq_in = '0;

        // R2 set
        for (int b = 0; b < NB; b++) begin
            p = 32'hA5C3_0F17 ^ (32'h1111_1111 * 32'(b));
            wr(b, 0, p);
            m_en[b] |= p;
        end
        check_all_enables("R2");
        wr(1, 0, 32'h0);
        check_all_enables("R2");
        for (int b = 0; b < NB; b++) begin
            rd(b, 1, v);
            chk("R4", 64'(v), 64'(m_en[b]));
            rd(b, 2, v);
            chk("R4", 64'(v), 64'd0);
        end

        // R3 clear
        for (int b = 0; b < NB; b++) begin
            p = 32'h0FF0_3C81 << b;
            wr(b, 1, p);
            m_en[b] &= ~p;
        end
        check_all_enables("R3");
        wr(3, 1, 32'h0);
        check_all_enables("R3");

        // R5 writes to pad / status offsets ignored
        wr(0, 2, 32'hFFFF_FFFF);
        wr(4, 3, 32'hFFFF_FFFF);
        wr(2, 3, 32'h0);
        check_all_enables("R5");

        // R8 out-of-range bank
        wr(5, 0, 32'hFFFF_FFFF);
        wr(7, 1, 32'hFFFF_FFFF);
        check_all_enables("R8");
        rd(6, 0, v);
        chk("R8", 64'(v), 64'd0);

        // R5/R6 status and combined outputs under patterns
        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < NI / 32; w++)
                pat[w*32 +: 32] = (32'h9E37_79B9 * 32'(w + 1)) ^ (32'h5A5A_00FF << k);
            @(negedge clk);
            irq_in = pat;
            @(negedge clk);
            chk("R6", 64'(group_irq), 64'(exp_groups(pat)));
            for (int b = 0; b < NB; b++) begin
                rd(b, 3, v);
                chk("R5", 64'(v), 64'(pat[b*32 +: 32] & m_en[b]));
            end
        end

        // R6 latency after enable write: one edge for enable, one for output
        @(negedge clk);
        irq_in = '0; irq_in[0] = 1'b1;
        wr(0, 1, 32'h0000_0001); m_en[0][0] = 1'b0;
        @(negedge clk);
        chk("R6", 64'(group_irq[0]), 64'd0);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(0); wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; m_en[0][0] = 1'b1;
        chk("R6", 64'(group_irq[0]), 64'd0);
        @(negedge clk);
        chk("R6", 64'(group_irq[0]), 64'd1);

        // R7 walking input with all lines enabled
        for (int b = 0; b < NB; b++) begin
            wr(b, 0, 32'hFFFF_FFFF);
            m_en[b] = 32'hFFFF_FFFF;
        end
        for (int i = 0; i < NI; i++) begin
            @(negedge clk);
            irq_in = '0; irq_in[i] = 1'b1;
            @(negedge clk);
            chk("R7", 64'(group_irq), 64'(NG'(1) << (i / 8)));
        end
        irq_in = '0;

        // R9 hold and read-during-write
        rd(3, 0, v);
        @(negedge clk);
        addr = AW'(1);
        @(negedge clk);
        chk("R9", 64'(rdata), 64'(v));
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = AW'(3 * 4 + 1); wdata = 32'hFFFF_0000;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9", 64'(rdata), 64'(m_en[3]));
        m_en[3] &= ~32'hFFFF_0000;
        rd(3, 0, v);
        chk("R9", 64'(v), 64'(m_en[3]));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule